// File: doc/BRIEF.md
# Chained Transfer Descriptor Walker

This block feeds a DMA channel engine with work from a chain of four-word descriptors in memory. Software writes the address of the first descriptor into a head register and strikes a start bit. The walker reads the descriptor one word at a time through a single-outstanding memory read port. It copies source, destination and length into the channel's working registers and pulses a load strobe to the engine. When the engine reports completion, the walker follows the descriptor's link word to the next descriptor, with no software action.

A link of zero ends the chain and raises a chain-complete flag. A chain may also close on itself, and then the walker keeps circling until software asks it to halt; the halt takes effect only between descriptors. A separate wrap register names a link value that redirects the walk to the head address. Every finished descriptor sets a sticky per-node flag, which drives the interrupt line through an enable bit.

Top module: `dll_loader`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `load_valid`, `node_sts`, `chain_sts` and `irq` are all 0.
- R2: A descriptor at byte address P is read as four words at P, P+4, P+8, P+12, in that order (source, destination, length, link). A new request is issued only after the previous one has returned `mem_rvalid`.
- R3: After the fourth word arrives, `load_valid` is high for exactly one cycle, with `cfg_src` = word 0, `cfg_dst` = word 1 and `cfg_len` = the low LW bits of word 2.
- R4: A `xfer_done` pulse while the engine runs makes the walker fetch the descriptor at the link word automatically.
- R5: A link word of zero sends the walker idle (`busy` 0) and sets `chain_sts`.
- R6: A chain whose links form a loop is walked repeatedly, descriptor after descriptor, until halted.
- R7: When a fetched link equals the nonzero value in the wrap register, the walk continues at the head address instead.
- R8: A halt request (control bit 1) made during a transfer lets that transfer finish, then the walker goes idle with no further fetch and `chain_sts` stays 0.
- R9: Each completed descriptor sets `node_sts`, which stays set until cleared.
- R10: Writing the status register (address 3) clears `node_sts` where bit 0 is 1 and `chain_sts` where bit 1 is 1; zero bits have no effect.
- R11: `irq` is 1 exactly when `node_sts` is 1 and the interrupt enable (control bit 2) is 1.
- R12: A start request while busy is ignored, and `xfer_done` outside a running transfer is ignored.
- R13: Starting with a head value of zero issues no memory read and sets `chain_sts` at once.

Register port: address 0 head pointer, 1 wrap value, 2 control (bit 0 start, bit 1 halt, bit 2 interrupt enable, written as a whole), 3 status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register select |
| reg_wr_data | input | 32 | Register write data |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | AW | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| load_valid | output | 1 | Working registers loaded, engine may start |
| cfg_src | output | AW | Working source address |
| cfg_dst | output | AW | Working destination address |
| cfg_len | output | LW | Working length |
| xfer_done | input | 1 | Engine completion pulse |
| busy | output | 1 | Walker not idle |
| node_sts | output | 1 | Sticky descriptor-done flag |
| chain_sts | output | 1 | Sticky chain-complete flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench aims at the seams between descriptors: a loop that would make a design stuck on a zero test spin forever or stop after one pass, a wrap value that a design missing the redirect would chase into an empty record, and a halt issued mid-transfer, where a design acting at once would drop the running transfer and one acting late would fetch an extra record. It also starts from a zero head, starts again while busy, and sends a stray completion while idle; a wrong design would read address 0, restart the chain or set the node flag. Random chains at scattered addresses with random memory latency catch an address step or word order that is off.

// File: rtl/dll_pkg.sv
package dll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_RUN,
    ST_WAIT_DONE
  } walk_state_e;

  localparam int REC_WORDS = 4;
  localparam int W_SRC     = 0;
  localparam int W_DST     = 1;
  localparam int W_LEN     = 2;
  localparam int W_LINK    = 3;

  localparam logic [1:0] RA_HEAD = 2'd0;
  localparam logic [1:0] RA_WRAP = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  localparam int CB_GO   = 0;
  localparam int CB_STOP = 1;
  localparam int CB_IEN  = 2;
  localparam int SB_NODE = 0;
  localparam int SB_CHN  = 1;
endpackage

// File: rtl/dll_regs.sv
module dll_regs
  import dll_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] wrap_o,
  output logic          irq_en_o,
  output logic          go_o,
  output logic          stop_o,
  output logic          clr_node_o,
  output logic          clr_chain_o
);
  logic [AW-1:0] head_q, wrap_q;
  logic          ien_q;
  logic          head_we, wrap_we, ctrl_we, stat_we;

  assign head_we = wr_en_i && (wr_addr_i == RA_HEAD);
  assign wrap_we = wr_en_i && (wr_addr_i == RA_WRAP);
  assign ctrl_we = wr_en_i && (wr_addr_i == RA_CTRL);
  assign stat_we = wr_en_i && (wr_addr_i == RA_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else if (head_we) begin
      head_q <= wr_data_i[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q <= '0;
    end else if (wrap_we) begin
      wrap_q <= wr_data_i[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
    end else if (ctrl_we) begin
      ien_q <= wr_data_i[CB_IEN];
    end
  end

  assign head_o      = head_q;
  assign wrap_o      = wrap_q;
  assign irq_en_o    = ien_q;
  assign go_o        = ctrl_we && wr_data_i[CB_GO];
  assign stop_o      = ctrl_we && wr_data_i[CB_STOP];
  assign clr_node_o  = stat_we && wr_data_i[SB_NODE];
  assign clr_chain_o = stat_we && wr_data_i[SB_CHN];
endmodule

// File: rtl/dll_fetch.sv
module dll_fetch
  import dll_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          active_i,
  input  logic [AW-1:0]                 base_i,
  output logic                          mem_req_o,
  output logic [AW-1:0]                 mem_addr_o,
  input  logic                          mem_rvalid_i,
  input  logic [DW-1:0]                 mem_rdata_i,
  output logic                          rec_done_o,
  output logic [REC_WORDS-1:0][DW-1:0]  rec_words_o
);
  localparam int IDX_W = $clog2(REC_WORDS);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pend_q, pend_d;
  logic             take;

  assign take = active_i && pend_q && mem_rvalid_i;

  always_comb begin
    idx_d  = idx_q;
    pend_d = pend_q;
    if (!active_i) begin
      idx_d  = '0;
      pend_d = 1'b0;
    end else if (!pend_q) begin
      pend_d = 1'b1;
    end else if (mem_rvalid_i) begin
      pend_d = 1'b0;
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      pend_q <= pend_d;
    end
  end

  for (genvar w = 0; w < REC_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rec_words_o[w] <= '0;
      end else if (take && (idx_q == IDX_W'(w))) begin
        rec_words_o[w] <= mem_rdata_i;
      end
    end
  end

  assign mem_req_o  = active_i && !pend_q;
  assign mem_addr_o = base_i + AW'({idx_q, 2'b00});
  assign rec_done_o = take && (idx_q == IDX_W'(REC_WORDS - 1));
endmodule

// File: rtl/dll_ctrl.sv
module dll_ctrl
  import dll_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go_i,
  input  logic                          stop_i,
  input  logic                          clr_node_i,
  input  logic                          clr_chain_i,
  input  logic [AW-1:0]                 head_i,
  input  logic [AW-1:0]                 wrap_i,
  input  logic                          rec_done_i,
  input  logic [REC_WORDS-1:0][DW-1:0]  rec_words_i,
  input  logic                          xfer_done_i,
  output logic                          fetch_active_o,
  output logic [AW-1:0]                 cur_ptr_o,
  output logic                          load_valid_o,
  output logic [AW-1:0]                 cfg_src_o,
  output logic [AW-1:0]                 cfg_dst_o,
  output logic [LW-1:0]                 cfg_len_o,
  output logic                          node_sts_o,
  output logic                          chain_sts_o,
  output logic                          busy_o
);
  walk_state_e   st_q, st_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] link_q;
  logic          stop_q, stop_d;
  logic          node_q, node_d;
  logic          chain_q, chain_d;
  logic          set_node, set_chain, clr_chain_go;
  logic          ld_en;
  logic [AW-1:0] link_fix;

  if (LW < DW) begin : g_len_trim
    logic unused_len_hi;
    assign unused_len_hi = ^rec_words_i[W_LEN][DW-1:LW];
  end

  assign ld_en    = (st_q == ST_LOAD);
  assign link_fix = ((wrap_i != '0) && (link_q == wrap_i)) ? head_i : link_q;

  always_comb begin
    st_d         = st_q;
    ptr_d        = ptr_q;
    stop_d       = stop_q;
    set_node     = 1'b0;
    set_chain    = 1'b0;
    clr_chain_go = 1'b0;
    if (stop_i && (st_q != ST_IDLE)) begin
      stop_d = 1'b1;
    end
    unique case (st_q)
      ST_IDLE: begin
        stop_d = 1'b0;
        if (go_i) begin
          if (head_i == '0) begin
            set_chain = 1'b1;
          end else begin
            clr_chain_go = 1'b1;
            ptr_d        = head_i;
            st_d         = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (rec_done_i) st_d = ST_LOAD;
      end
      ST_LOAD: begin
        st_d = ST_RUN;
      end
      ST_RUN: begin
        if (xfer_done_i) st_d = ST_WAIT_DONE;
      end
      ST_WAIT_DONE: begin
        set_node = 1'b1;
        if (stop_q || stop_i) begin
          stop_d = 1'b0;
          st_d   = ST_IDLE;
        end else if (link_q == '0) begin
          set_chain = 1'b1;
          st_d      = ST_IDLE;
        end else begin
          ptr_d = link_fix;
          st_d  = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    node_d  = (node_q && !clr_node_i) || set_node;
    chain_d = (chain_q && !clr_chain_i && !clr_chain_go) || set_chain;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      stop_q  <= 1'b0;
      node_q  <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      stop_q  <= stop_d;
      node_q  <= node_d;
      chain_q <= chain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_src_o <= '0;
      cfg_dst_o <= '0;
      cfg_len_o <= '0;
      link_q    <= '0;
    end else if (ld_en) begin
      cfg_src_o <= rec_words_i[W_SRC][AW-1:0];
      cfg_dst_o <= rec_words_i[W_DST][AW-1:0];
      cfg_len_o <= rec_words_i[W_LEN][LW-1:0];
      link_q    <= rec_words_i[W_LINK][AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_valid_o <= 1'b0;
    end else begin
      load_valid_o <= ld_en;
    end
  end

  assign fetch_active_o = (st_q == ST_FETCH);
  assign cur_ptr_o      = ptr_q;
  assign node_sts_o     = node_q;
  assign chain_sts_o    = chain_q;
  assign busy_o         = (st_q != ST_IDLE);
endmodule

// File: rtl/dll_loader.sv
module dll_loader
  import dll_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_wr_addr,
  input  logic [DW-1:0] reg_wr_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          load_valid,
  output logic [AW-1:0] cfg_src,
  output logic [AW-1:0] cfg_dst,
  output logic [LW-1:0] cfg_len,
  input  logic          xfer_done,
  output logic          busy,
  output logic          node_sts,
  output logic          chain_sts,
  output logic          irq
);
  logic [AW-1:0] head, wrap, cur_ptr;
  logic          irq_en, go, stop, clr_node, clr_chain;
  logic          fetch_active, rec_done;
  logic [REC_WORDS-1:0][DW-1:0] rec_words;

  dll_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (reg_wr_en),
    .wr_addr_i   (reg_wr_addr),
    .wr_data_i   (reg_wr_data),
    .head_o      (head),
    .wrap_o      (wrap),
    .irq_en_o    (irq_en),
    .go_o        (go),
    .stop_o      (stop),
    .clr_node_o  (clr_node),
    .clr_chain_o (clr_chain)
  );

  dll_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .active_i     (fetch_active),
    .base_i       (cur_ptr),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .rec_done_o   (rec_done),
    .rec_words_o  (rec_words)
  );

  dll_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .go_i           (go),
    .stop_i         (stop),
    .clr_node_i     (clr_node),
    .clr_chain_i    (clr_chain),
    .head_i         (head),
    .wrap_i         (wrap),
    .rec_done_i     (rec_done),
    .rec_words_i    (rec_words),
    .xfer_done_i    (xfer_done),
    .fetch_active_o (fetch_active),
    .cur_ptr_o      (cur_ptr),
    .load_valid_o   (load_valid),
    .cfg_src_o      (cfg_src),
    .cfg_dst_o      (cfg_dst),
    .cfg_len_o      (cfg_len),
    .node_sts_o     (node_sts),
    .chain_sts_o    (chain_sts),
    .busy_o         (busy)
  );

  assign irq = node_sts && irq_en;
endmodule

// File: rtl/dll_loader_chk.sv
module dll_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [1:0]  reg_wr_addr,
  input logic        clr_bit0,
  input logic        mem_req,
  input logic        load_valid,
  input logic        busy,
  input logic        node_sts,
  input logic        chain_sts
);
  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> !load_valid);

  p_load_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> busy);

  p_chain_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain_sts) |-> !busy);

  p_node_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (node_sts && !(reg_wr_en && (reg_wr_addr == 2'd3) && clr_bit0)) |=> node_sts);

  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind dll_loader dll_loader_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .clr_bit0    (reg_wr_data[0]),
  .mem_req     (mem_req),
  .load_valid  (load_valid),
  .busy        (busy),
  .node_sts    (node_sts),
  .chain_sts   (chain_sts)
);

// File: tb/sim_dll_loader.sv
module sim_dll_loader;
  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_addr;
  logic [31:0] reg_wr_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        load_valid;
  logic [31:0] cfg_src, cfg_dst;
  logic [15:0] cfg_len;
  logic        xfer_done, eng_done, tb_done;
  logic        busy, node_sts, chain_sts, irq;

  int n_chk, n_err, cyc;
  logic [31:0] mem [0:255];
  logic [31:0] ld_src [0:63];
  logic [31:0] ld_dst [0:63];
  logic [15:0] ld_len [0:63];
  logic [31:0] rq_addr [0:255];
  logic [31:0] exp_ptr [0:63];
  int ld_n, rq_n, proto_err, mcnt, ecnt;
  logic [31:0] maddr;

  assign xfer_done = eng_done | tb_done;

  dll_loader u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .load_valid(load_valid),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len), .xfer_done(xfer_done),
    .busy(busy), .node_sts(node_sts), .chain_sts(chain_sts), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (mcnt > 0) begin
      if (mem_req) proto_err++;
      mcnt--;
      if (mcnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[maddr[9:2]];
      end
    end else if (mem_req) begin
      maddr = mem_addr;
      if (rq_n < 256) rq_addr[rq_n] = mem_addr;
      rq_n++;
      mcnt = 1 + int'($urandom % 3);
    end
  end

  always @(negedge clk) begin
    eng_done = 1'b0;
    if (ecnt > 0) begin
      ecnt--;
      if (ecnt == 0) eng_done = 1'b1;
    end
    if (load_valid) begin
      if (ld_n < 64) begin
        ld_src[ld_n] = cfg_src; ld_dst[ld_n] = cfg_dst; ld_len[ld_n] = cfg_len;
      end
      ld_n++;
      ecnt = 3 + int'($urandom % 3);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic put(input logic [31:0] p, input logic [31:0] s, input logic [31:0] d,
                     input logic [31:0] l, input logic [31:0] nx);
    mem[p[9:2]] = s; mem[p[9:2] + 8'd1] = d; mem[p[9:2] + 8'd2] = l; mem[p[9:2] + 8'd3] = nx;
  endtask

  task automatic clear_logs();
    ld_n = 0; rq_n = 0; proto_err = 0;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 8000) begin
      @(negedge clk); t++;
    end
    check(tag, 32'(busy), 32'd0);
  endtask

  function automatic int walk(input logic [31:0] head, input logic [31:0] wrp, input int maxn);
    logic [31:0] p = head;
    int n = 0;
    while (p != 0 && n < maxn) begin
      exp_ptr[n] = p;
      n++;
      p = mem[p[9:2] + 8'd3];
      if (wrp != 0 && p == wrp) p = head;
    end
    return n;
  endfunction

  task automatic check_loads(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = exp_ptr[i][9:2];
      check(tag, ld_src[i], mem[b]);
      check(tag, ld_dst[i], mem[b + 8'd1]);
      check(tag, 32'(ld_len[i]), 32'(mem[b + 8'd2][15:0]));
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    n_chk = 0; n_err = 0; cyc = 0;
    ld_n = 0; rq_n = 0; proto_err = 0; mcnt = 0; ecnt = 0;
    reg_wr_en = 0; reg_wr_addr = 0; reg_wr_data = 0;
    mem_rvalid = 0; mem_rdata = 0; eng_done = 0; tb_done = 0; maddr = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 load_valid", 32'(load_valid), 0);
    check("R1 node", 32'(node_sts), 0);
    check("R1 chain", 32'(chain_sts), 0);
    check("R1 irq", 32'(irq), 0);

    // Directed three-record chain
    put(32'h40, 32'h1111_0000, 32'h2222_0000, 32'h0000_1234, 32'h80);
    put(32'h80, 32'h1111_0004, 32'h2222_0004, 32'hABCD_0040, 32'hC0);
    put(32'hC0, 32'h1111_0008, 32'h2222_0008, 32'h0000_FFFF, 32'h0);
    wr(2'd0, 32'h40);
    wr(2'd1, 32'h0);
    clear_logs();
    wr(2'd2, 32'h1);
    wait_idle("R5 idle");
    n = walk(32'h40, 32'h0, 64);
    check("R4 count", 32'(ld_n), 32'(n));
    check_loads("R3 fields", n);
    check("R2 reqs", 32'(rq_n), 32'(4 * n));
    for (int k = 0; k < n; k++)
      for (int w = 0; w < 4; w++)
        check("R2 order", rq_addr[4 * k + w], exp_ptr[k] + 32'(4 * w));
    check("R2 one outstanding", 32'(proto_err), 0);
    check("R5 chain", 32'(chain_sts), 1);
    check("R9 node", 32'(node_sts), 1);
    check("R11 masked", 32'(irq), 0);
    wr(2'd2, 32'h4);
    check("R11 enabled", 32'(irq), 1);

    // R10 write-one-to-clear
    wr(2'd3, 32'h0);
    check("R10 zero node", 32'(node_sts), 1);
    check("R10 zero chain", 32'(chain_sts), 1);
    wr(2'd3, 32'h1);
    check("R10 clr node", 32'(node_sts), 0);
    check("R10 keep chain", 32'(chain_sts), 1);
    check("R11 cleared", 32'(irq), 0);
    wr(2'd3, 32'h2);
    check("R10 clr chain", 32'(chain_sts), 0);

    // R12 stray completion while idle
    tb_done = 1'b1;
    @(negedge clk);
    tb_done = 1'b0;
    @(negedge clk);
    check("R12 stray done", 32'(node_sts), 0);
    check("R12 stay idle", 32'(busy), 0);

    // R13 zero head
    clear_logs();
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h5);
    @(negedge clk);
    check("R13 chain", 32'(chain_sts), 1);
    check("R13 no read", 32'(rq_n), 0);
    check("R13 idle", 32'(busy), 0);
    wr(2'd3, 32'h3);

    // R6 ring, R12 go while busy, R8 halt
    put(32'h100, 32'hAAAA_0001, 32'hBBBB_0001, 32'h10, 32'h140);
    put(32'h140, 32'hAAAA_0002, 32'hBBBB_0002, 32'h20, 32'h100);
    wr(2'd0, 32'h100);
    clear_logs();
    wr(2'd2, 32'h5);
    wait (ld_n == 2);
    wr(2'd0, 32'h40);
    wr(2'd2, 32'h5);
    wait (ld_n == 5);
    wr(2'd2, 32'h6);
    wait_idle("R8 idle");
    repeat (10) @(negedge clk);
    n = walk(32'h100, 32'h0, 5);
    check("R8 count", 32'(ld_n), 5);
    check_loads("R6 ring", n);
    check("R8 no chain", 32'(chain_sts), 0);
    check("R8 no extra fetch", 32'(rq_n), 20);
    check("R9 node ring", 32'(node_sts), 1);
    wr(2'd3, 32'h3);

    // R7 wrap redirect
    put(32'h200, 32'hC0C0_0001, 32'hD0D0_0001, 32'h7, 32'h240);
    put(32'h240, 32'hC0C0_0002, 32'hD0D0_0002, 32'h8, 32'h280);
    put(32'h280, 32'hC0C0_0003, 32'hD0D0_0003, 32'h9, 32'h3C0);
    put(32'h3C0, 32'h0, 32'h0, 32'h0, 32'h0);
    wr(2'd0, 32'h200);
    wr(2'd1, 32'h3C0);
    clear_logs();
    wr(2'd2, 32'h1);
    wait (ld_n == 7);
    wr(2'd2, 32'h2);
    wait_idle("R7 idle");
    n = walk(32'h200, 32'h3C0, 7);
    check("R7 count", 32'(ld_n), 7);
    check_loads("R7 wrap", n);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h3);

    // Random chains, R2 R3 R4 R5
    for (int t = 0; t < 20; t++) begin
      int len = 1 + int'($urandom % 6);
      int s0  = int'($urandom % 60);
      logic [31:0] a [0:5];
      for (int i = 0; i < len; i++) a[i] = 32'(16 * (1 + (s0 + 7 * i) % 60));
      for (int i = 0; i < len; i++)
        put(a[i], $urandom, $urandom, $urandom, (i == len - 1) ? 32'h0 : a[i + 1]);
      wr(2'd0, a[0]);
      clear_logs();
      wr(2'd2, 32'h1);
      wait_idle("R5 rnd idle");
      n = walk(a[0], 32'h0, 64);
      check("R4 rnd count", 32'(ld_n), 32'(n));
      check_loads("R3 rnd", n);
      check("R2 rnd reqs", 32'(rq_n), 32'(4 * n));
      check("R2 rnd proto", 32'(proto_err), 0);
      check("R5 rnd chain", 32'(chain_sts), 1);
      wr(2'd3, 32'h3);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule